// File: doc/BRIEF.md
# Synthesizer Serial Register Loader

This block programs an external integer-N frequency synthesizer through its three-wire serial configuration port: a serial clock, a data line and a load-enable strobe. The synthesizer keeps four 24-bit control latches: initialization, function, reference divider and feedback divider. Each word carries its own two-bit latch address in its lowest bits. The loader shifts every word out one bit per serial clock into the device's holding register. It then pulses load-enable so that the device moves the word into the latch named by its address.

The feedback-divider word is built from the A counter (6 bits) and B counter (13 bits) of a dual-modulus divide ratio N = P·B + A. Those two values come from a separate step controller. The other three words are fixed. The reference word sets a divide-by-40 reference. A full reload starts on a start request, and it also starts by itself whenever the A/B inputs differ from the values used in the last reload. A request that arrives during a reload is held and served once the current reload is complete.

Top module: `synth_cfg_loader`

## Requirements
- R1: A start pulse while the block is idle raises busy on the next clock and starts a reload of all four words.
- R2: Each reload sends four words in this order, with these address values in bits [1:0]: initialization (11), function (10), reference divider (00), feedback divider (01).
- R3: Each word is exactly 24 bits and is sent MSB first. The data line changes only while the serial clock is low, and it is stable on every rising edge of the serial clock.
- R4: After the 24th bit of each word, load-enable is high for exactly LE_HOLD system clocks (default 2), and the serial clock stays low for that whole time.
- R5: Within a word, every high phase of the serial clock lasts CLK_DIV system clocks. Every low phase between two bits also lasts CLK_DIV system clocks (default 2).
- R6: Busy stays high from the start of a reload until after the last load-enable pulse has ended. done is a one-clock pulse that comes in the first cycle in which busy is low again. While busy is low, the serial clock and load-enable are low.
- R7: The fixed words are 0x003093 (initialization), 0x003092 (function) and 0x6200A0 (reference). The feedback word is {3'b001, B[12:0], A[5:0], 2'b01}, which gives 0x200819 for A=6, B=8.
- R8: When the block is idle and the A/B inputs differ from the values of the last reload, a reload starts on the next clock with no start pulse and uses the new values.
- R9: A start pulse or an A/B change that arrives during a reload does not abort that reload. The reload finishes with the values captured when it began, and a second full reload follows.
- R10: After reset, all serial pins, busy and done are low. With A=6 and B=8 applied, no word is sent until a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request for a full reload of the four words |
| a_cnt_i | input | 6 | A counter value for the feedback divider |
| b_cnt_i | input | 13 | B counter value for the feedback divider |
| busy_o | output | 1 | High while a reload is in progress |
| done_o | output | 1 | One-cycle pulse when a reload completes |
| sclk_o | output | 1 | Serial clock to the synthesizer |
| sdata_o | output | 1 | Serial data to the synthesizer |
| sle_o | output | 1 | Load-enable strobe to the synthesizer |

## Verification
The assertions accept start pulses and A/B changes at any time, including during a reload. They do assume that the A/B inputs are synchronous to the system clock, so that the idle-time change comparison is clean. The stimulus changes A and B only on falling clock edges and holds each value until the reload that uses it has finished. The random values keep B at or above A, which is a valid setting for a dual-modulus divider. The fixed-seed random values are mixed with the all-zero and all-ones extremes of A and B.

// File: rtl/synth_cfg_pkg.sv
// Package: shared constants, latch addresses and word builders for the
// synthesizer serial register loader. Assumes a 24-bit control word with
// a two-bit latch address in bits [1:0].
package synth_cfg_pkg;

    localparam int WORD_W = 24;
    localparam int A_W    = 6;
    localparam int B_W    = 13;
    localparam int SLOT_W = 2;
    localparam int N_WORDS = 4;

    typedef enum logic [1:0] {
        ADDR_REF  = 2'b00,
        ADDR_FB   = 2'b01,
        ADDR_FUNC = 2'b10,
        ADDR_INIT = 2'b11
    } latch_addr_e;

    localparam logic [WORD_W-1:0] WORD_REF  = 24'h6200A0;
    localparam logic [WORD_W-1:0] WORD_FB   = 24'h200819;
    localparam logic [WORD_W-1:0] WORD_FUNC = 24'h003092;
    localparam logic [WORD_W-1:0] WORD_INIT = 24'h003093;

    localparam int FB_A_LSB = 2;
    localparam int FB_B_LSB = FB_A_LSB + A_W;
    localparam int FB_TOP_LSB = FB_B_LSB + B_W;

    localparam logic [A_W-1:0] RESET_A = WORD_FB[FB_B_LSB-1:FB_A_LSB];
    localparam logic [B_W-1:0] RESET_B = WORD_FB[FB_TOP_LSB-1:FB_B_LSB];

    // Latch order of a reload: slot index to latch address.
    function automatic latch_addr_e slot_to_addr(input logic [SLOT_W-1:0] slot);
        case (slot)
            2'd0:    return ADDR_INIT;
            2'd1:    return ADDR_FUNC;
            2'd2:    return ADDR_REF;
            default: return ADDR_FB;
        endcase
    endfunction

    // Feedback-divider word: fixed high bits, B, A, then the address.
    function automatic logic [WORD_W-1:0] build_fb_word(input logic [A_W-1:0] a,
                                                        input logic [B_W-1:0] b);
        return {WORD_FB[WORD_W-1:FB_TOP_LSB], b, a, ADDR_FB};
    endfunction

endpackage

// File: rtl/synth_word_select.sv
// Module: picks the control word for a given reload slot.
// Assumes A/B are already captured and stable for the whole reload.
module synth_word_select
    import synth_cfg_pkg::*;
(
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [A_W-1:0]    a_i,
    input  logic [B_W-1:0]    b_i,
    output logic [WORD_W-1:0] word_o
);

    // Purpose: map the slot to its latch and return that latch's word.
    always_comb begin
        case (slot_to_addr(slot_i))
            ADDR_INIT: word_o = WORD_INIT;
            ADDR_FUNC: word_o = WORD_FUNC;
            ADDR_REF:  word_o = WORD_REF;
            default:   word_o = build_fb_word(a_i, b_i);
        endcase
    end

endmodule

// File: rtl/synth_serial_shifter.sv
// Module: shifts one word out MSB first on a divided serial clock, then
// holds load-enable for LE_HOLD system clocks. Data moves on the falling
// serial clock edge. Assumes go_i is only pulsed while the shifter is idle.
module synth_serial_shifter #(
    parameter int WORD_W  = 24,
    parameter int CLK_DIV = 2,
    parameter int LE_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sle_o,
    output logic              done_o
);

    localparam int CNT_MAX = (CLK_DIV > LE_HOLD) ? CLK_DIV : LE_HOLD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BIT_W   = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] DIV_LAST  = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(LE_HOLD - 1);

    typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_LATCH} sh_state_e;

    sh_state_e         state;
    logic [WORD_W-1:0] shreg;
    logic [BIT_W-1:0]  bits_left;
    logic [CNT_W-1:0]  cnt;

    assign sdata_o = shreg[WORD_W-1];

    // Purpose: serial clock phases, bit shifting and load-enable timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SH_IDLE;
            shreg     <= '0;
            bits_left <= '0;
            cnt       <= '0;
            sclk_o    <= 1'b0;
            sle_o     <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (go_i) begin
                        shreg     <= word_i;
                        bits_left <= BIT_W'(WORD_W);
                        cnt       <= '0;
                        state     <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (cnt == DIV_LAST) begin
                        cnt    <= '0;
                        sclk_o <= 1'b1;
                        state  <= SH_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (cnt == DIV_LAST) begin
                        cnt    <= '0;
                        sclk_o <= 1'b0;
                        if (bits_left == BIT_W'(1)) begin
                            sle_o <= 1'b1;
                            state <= SH_LATCH;
                        end else begin
                            shreg     <= {shreg[WORD_W-2:0], 1'b0};
                            bits_left <= bits_left - 1'b1;
                            state     <= SH_LOW;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == HOLD_LAST) begin
                        cnt    <= '0;
                        sle_o  <= 1'b0;
                        done_o <= 1'b1;
                        state  <= SH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R4: load-enable is never high together with the serial clock.
    p_le_sclk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sle_o |-> !sclk_o);

    // R3: data does not move in the cycle the serial clock is high.
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdata_o));

    generate
        if (LE_HOLD >= 2) begin : g_le_width
            // R4: a rising load-enable stays high for at least a second cycle.
            p_le_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sle_o) |=> sle_o);
        end
    endgenerate

endmodule

// File: rtl/synth_cfg_loader.sv
// Module: top of the synthesizer serial register loader. It sequences
// four-word reloads (initialization, function, reference, feedback) on
// start or on a change of A/B, and it queues requests that arrive while busy.
// Assumes A/B inputs are synchronous to clk.
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int LE_HOLD = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [A_W-1:0] a_cnt_i,
    input  logic [B_W-1:0] b_cnt_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           sclk_o,
    output logic           sdata_o,
    output logic           sle_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_WORDS - 1);

    typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_state_e;

    sq_state_e         state;
    logic [SLOT_W-1:0] slot;
    logic              pending;
    logic [A_W-1:0]    snap_a;
    logic [B_W-1:0]    snap_b;
    logic [WORD_W-1:0] cur_word;
    logic              word_done;
    logic              go;
    logic              changed;

    assign changed = (a_cnt_i != snap_a) || (b_cnt_i != snap_b);
    assign go      = (state == SQ_ISSUE);
    assign busy_o  = (state != SQ_IDLE);

    // Purpose: reload sequencing, request queuing and A/B capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            slot    <= '0;
            pending <= 1'b0;
            snap_a  <= RESET_A;
            snap_b  <= RESET_B;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                pending <= 1'b1;
            end
            case (state)
                SQ_IDLE: begin
                    if (start_i || pending || changed) begin
                        snap_a  <= a_cnt_i;
                        snap_b  <= b_cnt_i;
                        slot    <= '0;
                        pending <= 1'b0;
                        state   <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    state <= SQ_WAIT;
                end
                default: begin
                    if (word_done) begin
                        if (slot == LAST_SLOT) begin
                            done_o <= 1'b1;
                            state  <= SQ_IDLE;
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= SQ_ISSUE;
                        end
                    end
                end
            endcase
        end
    end

    synth_word_select u_word_sel (
        .slot_i (slot),
        .a_i    (snap_a),
        .b_i    (snap_b),
        .word_o (cur_word)
    );

    synth_serial_shifter #(
        .WORD_W  (WORD_W),
        .CLK_DIV (CLK_DIV),
        .LE_HOLD (LE_HOLD)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .word_i  (cur_word),
        .sclk_o  (sclk_o),
        .sdata_o (sdata_o),
        .sle_o   (sle_o),
        .done_o  (word_done)
    );

    // R1: a start request while idle raises busy on the next clock.
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6: done marks the first idle cycle after a reload.
    p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R6: serial clock and load-enable are quiet while idle.
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !sle_o));

    // R8: new A/B values seen while idle start a reload.
    p_auto_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && changed) |=> busy_o);

endmodule

// File: tb/synth_cfg_loader_tb.sv
// Bench: reconstructs every serial word at the pins and compares it with
// words computed from the requirements. Uses fixed-seed random A/B values
// and directed corner cases.
module synth_cfg_loader_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 2;
    localparam int LE_HOLD    = 2;
    localparam int QMAX       = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  a_cnt_i = 6'd6;
    logic [12:0] b_cnt_i = 13'd8;
    logic        busy_o, done_o, sclk_o, sdata_o, sle_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_cfg_loader #(.CLK_DIV(CLK_DIV), .LE_HOLD(LE_HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .a_cnt_i(a_cnt_i), .b_cnt_i(b_cnt_i),
        .busy_o(busy_o), .done_o(done_o),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .sle_o(sle_o));

    // Serial receiver model.
    logic [23:0] rx_sh = '0;
    int          rx_bits = 0;
    logic [23:0] wq [QMAX];
    int          wbits [QMAX];
    int          wcount = 0;

    always @(posedge sclk_o) begin
        rx_sh   = {rx_sh[22:0], sdata_o};
        rx_bits = rx_bits + 1;
    end

    always @(posedge sle_o) begin
        if (wcount < QMAX) begin
            wq[wcount]    = rx_sh;
            wbits[wcount] = rx_bits;
        end
        wcount  = wcount + 1;
        rx_bits = 0;
    end

    // Timing monitor, sampled on the falling system clock edge.
    int   timing_err = 0;
    int   le_err = 0;
    int   seq_err = 0;
    int   done_count = 0;
    int   sclk_run = 0;
    int   le_run = 0;
    logic sclk_prev = 1'b0;
    logic le_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o != sclk_prev) begin
                if (!sclk_o && sclk_run != CLK_DIV) timing_err++;
                if (sclk_o && rx_bits >= 2 && sclk_run != CLK_DIV) timing_err++;
                sclk_run = 1;
            end else begin
                sclk_run++;
            end
            if (sle_o && sclk_o) le_err++;
            if (sle_o) le_run++;
            if (!sle_o && le_prev) begin
                if (le_run != LE_HOLD) le_err++;
                le_run = 0;
            end
            if (done_o) begin
                done_count++;
                if (busy_o) seq_err++;
            end
            if (!busy_o && (sclk_o || sle_o)) seq_err++;
            sclk_prev = sclk_o;
            le_prev   = sle_o;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_fb(input logic [5:0] a, input logic [12:0] b);
        return {3'b001, b, a, 2'b01};
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Checks four words starting at base against the expected reload.
    task automatic expect_reload(input int base, input logic [5:0] a, input logic [12:0] b);
        logic [23:0] exp_w [4];
        exp_w[0] = 24'h003093;
        exp_w[1] = 24'h003092;
        exp_w[2] = 24'h6200A0;
        exp_w[3] = exp_fb(a, b);
        chk("R2 word count", 32'(wcount - base), 32'd4);
        for (int k = 0; k < 4; k++) begin
            if (base + k < QMAX) begin
                chk((k == 3) ? "R7 feedback word" : "R7 fixed word", 32'(wq[base+k]), 32'(exp_w[k]));
                chk("R2 address order", 32'(wq[base+k][1:0]), 32'(exp_w[k][1:0]));
                chk("R3 bits per word", 32'(wbits[base+k]), 32'd24);
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int base;
        int dc;
        logic [5:0]  ra, prev_a;
        logic [12:0] rb, prev_b;
        void'($urandom(32'h5EED_1234));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state of the pins.
        chk("R10 sclk reset", 32'(sclk_o), 0);
        chk("R10 sdata reset", 32'(sdata_o), 0);
        chk("R10 sle reset", 32'(sle_o), 0);
        chk("R10 busy reset", 32'(busy_o), 0);
        chk("R10 done reset", 32'(done_o), 0);
        repeat (50) @(negedge clk);
        chk("R10 no load without start", 32'(wcount), 0);
        chk("R10 idle without start", 32'(busy_o), 0);

        // R1: directed start with default values.
        base = wcount;
        dc = done_count;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 busy after start", 32'(busy_o), 1);
        wait_idle();
        expect_reload(base, 6'd6, 13'd8);
        @(negedge clk);
        chk("R6 one done pulse", 32'(done_count - dc), 1);
        prev_a = 6'd6;
        prev_b = 13'd8;

        // R8: random and corner A/B values, each starting a reload by itself.
        for (int it = 0; it < 14; it++) begin
            if (it == 0) begin
                ra = 6'd63; rb = 13'd8191;
            end else if (it == 1) begin
                ra = 6'd0;  rb = 13'd0;
            end else begin
                ra = 6'($urandom % 64);
                rb = 13'($urandom_range(8191, 63));
            end
            base = wcount;
            @(negedge clk);
            a_cnt_i = ra;
            b_cnt_i = rb;
            if (ra == prev_a && rb == prev_b) begin
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end else begin
                @(negedge clk);
            end
            chk("R8 auto reload busy", 32'(busy_o), 1);
            wait_idle();
            expect_reload(base, ra, rb);
            prev_a = ra;
            prev_b = rb;
        end

        // R9: change A/B during a reload; the current reload keeps old values.
        base = wcount;
        pulse_start();
        repeat (30) @(negedge clk);
        a_cnt_i = 6'd21;
        b_cnt_i = 13'd1234;
        wait_idle();
        expect_reload(base, prev_a, prev_b);
        @(negedge clk);
        chk("R9 queued change reloads", 32'(busy_o), 1);
        base = wcount;
        wait_idle();
        expect_reload(base, 6'd21, 13'd1234);

        // R9: start during a reload queues a second reload with the same values.
        base = wcount;
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        wait_idle();
        @(negedge clk);
        chk("R9 queued start reloads", 32'(busy_o), 1);
        wait_idle();
        chk("R9 eight words", 32'(wcount - base), 8);
        expect_reload(base + 4, 6'd21, 13'd1234);

        repeat (10) @(negedge clk);
        chk("R5 serial clock phases", 32'(timing_err), 0);
        chk("R4 load-enable width", 32'(le_err), 0);
        chk("R6 busy and done framing", 32'(seq_err), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule